// File: doc/BRIEF.md
# Sequence-Phase Commit Arbiter

This block decides which processor may broadcast its buffered writes on a shared commit network. Every processor keeps an entry in a tag table that records whether it has a live transaction, the ordering group (sequence) that transaction belongs to, and its age within that group (phase). A request is eligible only when no live transaction in the same sequence has a lower phase. Transactions in different sequences never wait for one another. Several transactions may share a phase, and then any of them can commit.

At most one commit runs at a time. Among the eligible requesters, the next holder is chosen round-robin. The holder keeps its grant until it pulses its done line. At that point its table phase advances by the supplied increment. An increment of zero splits a transaction and keeps its place. An increment of one or more acts as a barrier against its peers. A done line can also ask the processor to wait for another sequence to drain. That processor is then held until no other live entry belongs to the named sequence.

A holder that requested in overflow mode writes straight to memory. Its grant ignores done and lasts until the end report for that processor arrives. End reports write a table entry directly and can remove the transaction from ordering.

Top module: `seqph_commit_arb`

## Requirements
- R1: After reset, grant and busy are 0, no processor is held, and every table entry is inactive.
- R2: At most one grant bit is set in any cycle, and busy is 1 exactly when a grant bit is set.
- R3: A request with sequence s and phase p is granted only if no active table entry with sequence s has a phase lower than p. Phases compare as unsigned numbers, and equal phases do not block.
- R4: Active entries in other sequences never block a request, whatever their phases.
- R5: When several requests are eligible, the next grant goes to the first eligible processor after the previous holder in ascending index order, wrapping around. After reset the search starts at processor 0.
- R6: A normal grant stays set until the holder's done is 1. The grant then clears at that clock edge, and the holder's table phase becomes phase + done_inc at the same edge.
- R7: A done_inc of 0 leaves the holder's order unchanged. A done_inc of 1 or more moves it behind peers of its sequence that are still at the old phase, until they too advance.
- R8: A done with done_wait = 1 sets the holder's hold bit at the same edge. The hold bit clears on the first edge at which no other processor's active entry has sequence done_wseq.
- R9: A grant given to a request with req_ovf = 1 ignores done. It lasts until rpt_valid is 1 for that processor, and no other processor is granted meanwhile.
- R10: rpt_valid[i] writes entry i with rpt_active, rpt_seq and rpt_phase at the next edge. This takes priority over a done update in the same cycle. An entry written with rpt_active = 0 no longer takes part in ordering. An end report for the current holder also ends its grant.
- R11: A grant is registered. It appears on the clock edge after a cycle in which the block is idle and the request is eligible, so after a release there is one idle cycle before the next holder is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N | Commit request per processor |
| req_ovf | input | N | Request is in overflow (write-through) mode |
| req_seq | input | N*SEQ_W | Sequence of each request |
| req_phase | input | N*PH_W | Phase of each request |
| done | input | N | Holder finished its commit |
| done_inc | input | PH_W | Phase increment applied on done |
| done_wait | input | 1 | Done also starts a wait for a sequence |
| done_wseq | input | SEQ_W | Sequence to wait for |
| rpt_valid | input | N | Transaction-end report per processor |
| rpt_active | input | 1 | Reported entry has a live transaction |
| rpt_seq | input | N*SEQ_W | Reported sequence per processor |
| rpt_phase | input | N*PH_W | Reported phase per processor |
| grant | output | N | One-hot commit permission |
| busy | output | 1 | Commit network in use |
| hold | output | N | Processor waiting for a sequence to drain |

## Verification
The case that is hardest to reach from the ports is a request that is blocked only by a lower phase that the block itself wrote: a barrier commit. To get there, the stimulus lets one processor commit with a nonzero increment and keeps it requesting at its new phase while a peer stays idle at the old phase. It then shows that no grant appears until the peer has committed. A second case that is hard to reach is an overflow holder ignoring done while a request from an independent sequence waits. That case is forced by raising both requests while the overflow grant is held and checking that the grant does not move until the end report for the holder arrives.

// File: rtl/seqph_pkg.sv
package seqph_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_HELD = 2'd1,
    ARB_OVF  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/seqph_tag_table.sv
module seqph_tag_table #(
  parameter int N     = 4,
  parameter int SEQ_W = 2,
  parameter int PH_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       rpt_valid,
  input  logic               rpt_active,
  input  logic [N*SEQ_W-1:0] rpt_seq,
  input  logic [N*PH_W-1:0]  rpt_phase,
  input  logic [N-1:0]       upd_en,
  input  logic [PH_W-1:0]    upd_inc,
  input  logic               upd_wait,
  input  logic [SEQ_W-1:0]   upd_wseq,
  output logic [N-1:0]       tab_act,
  output logic [N*SEQ_W-1:0] tab_seq,
  output logic [N*PH_W-1:0]  tab_ph,
  output logic [N-1:0]       hold
);
  logic [SEQ_W-1:0] wseq_q [N];
  logic [N-1:0]     drained;

  // A waited sequence is drained when no other live entry carries it
  always_comb begin
    for (int i = 0; i < N; i++) begin
      drained[i] = 1'b1;
      for (int j = 0; j < N; j++) begin
        if (j != i && tab_act[j] && tab_seq[j*SEQ_W +: SEQ_W] == wseq_q[i])
          drained[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        tab_act[i]                 <= 1'b0;
        tab_seq[i*SEQ_W +: SEQ_W]  <= '0;
        tab_ph[i*PH_W +: PH_W]     <= '0;
        hold[i]                    <= 1'b0;
        wseq_q[i]                  <= '0;
      end else begin
        if (rpt_valid[i]) begin
          tab_act[i]                <= rpt_active;
          tab_seq[i*SEQ_W +: SEQ_W] <= rpt_seq[i*SEQ_W +: SEQ_W];
          tab_ph[i*PH_W +: PH_W]    <= rpt_phase[i*PH_W +: PH_W];
        end else if (upd_en[i]) begin
          tab_ph[i*PH_W +: PH_W]    <= tab_ph[i*PH_W +: PH_W] + upd_inc;
        end
        if (upd_en[i] && upd_wait) begin
          hold[i]   <= 1'b1;
          wseq_q[i] <= upd_wseq;
        end else if (hold[i] && drained[i]) begin
          hold[i]   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/seqph_elig.sv
module seqph_elig #(
  parameter int N     = 4,
  parameter int SEQ_W = 2,
  parameter int PH_W  = 4
) (
  input  logic [N-1:0]       req,
  input  logic [N*SEQ_W-1:0] req_seq,
  input  logic [N*PH_W-1:0]  req_phase,
  input  logic [N-1:0]       tab_act,
  input  logic [N*SEQ_W-1:0] tab_seq,
  input  logic [N*PH_W-1:0]  tab_ph,
  output logic [N-1:0]       elig
);
  logic [N-1:0] blocked;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (tab_act[j]
            && tab_seq[j*SEQ_W +: SEQ_W] == req_seq[i*SEQ_W +: SEQ_W]
            && tab_ph[j*PH_W +: PH_W] < req_phase[i*PH_W +: PH_W])
          blocked[i] = 1'b1;
      end
    end
  end

  assign elig = req & ~blocked;
endmodule

// File: rtl/seqph_rr_pick.sv
module seqph_rr_pick #(
  parameter int N = 4,
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     elig,
  input  logic [PTR_W-1:0] last,
  output logic [N-1:0]     pick,
  output logic [PTR_W-1:0] pick_idx,
  output logic             any
);
  int idx;

  always_comb begin
    pick     = '0;
    pick_idx = '0;
    any      = 1'b0;
    idx      = 0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last) + k) % N;
      if (!any && elig[idx]) begin
        pick[idx] = 1'b1;
        pick_idx  = PTR_W'(idx);
        any       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/seqph_commit_arb.sv
module seqph_commit_arb #(
  parameter int N     = 4,
  parameter int SEQ_W = 2,
  parameter int PH_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       req,
  input  logic [N-1:0]       req_ovf,
  input  logic [N*SEQ_W-1:0] req_seq,
  input  logic [N*PH_W-1:0]  req_phase,
  input  logic [N-1:0]       done,
  input  logic [PH_W-1:0]    done_inc,
  input  logic               done_wait,
  input  logic [SEQ_W-1:0]   done_wseq,
  input  logic [N-1:0]       rpt_valid,
  input  logic               rpt_active,
  input  logic [N*SEQ_W-1:0] rpt_seq,
  input  logic [N*PH_W-1:0]  rpt_phase,
  output logic [N-1:0]       grant,
  output logic               busy,
  output logic [N-1:0]       hold
);
  import seqph_pkg::*;
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  arb_state_e         st_q;
  logic [PTR_W-1:0]   last_q;
  logic [N-1:0]       tab_act;
  logic [N*SEQ_W-1:0] tab_seq;
  logic [N*PH_W-1:0]  tab_ph;
  logic [N-1:0]       elig_w;
  logic [N-1:0]       pick;
  logic [PTR_W-1:0]   pick_idx;
  logic               pick_any;
  logic [N-1:0]       upd_en;
  logic               release_w;
  logic               ovf_held_w;

  assign ovf_held_w = (st_q == ARB_OVF);
  assign upd_en     = (st_q == ARB_HELD) ? (grant & done) : '0;
  assign release_w  = ((st_q == ARB_HELD) && ((grant & (done | rpt_valid)) != '0))
                   || ((st_q == ARB_OVF) && ((grant & rpt_valid) != '0));

  seqph_tag_table #(.N(N), .SEQ_W(SEQ_W), .PH_W(PH_W)) u_tab (
    .clk(clk), .rst(rst),
    .rpt_valid(rpt_valid), .rpt_active(rpt_active),
    .rpt_seq(rpt_seq), .rpt_phase(rpt_phase),
    .upd_en(upd_en), .upd_inc(done_inc),
    .upd_wait(done_wait), .upd_wseq(done_wseq),
    .tab_act(tab_act), .tab_seq(tab_seq), .tab_ph(tab_ph),
    .hold(hold)
  );

  seqph_elig #(.N(N), .SEQ_W(SEQ_W), .PH_W(PH_W)) u_elig (
    .req(req), .req_seq(req_seq), .req_phase(req_phase),
    .tab_act(tab_act), .tab_seq(tab_seq), .tab_ph(tab_ph),
    .elig(elig_w)
  );

  seqph_rr_pick #(.N(N)) u_pick (
    .elig(elig_w), .last(last_q),
    .pick(pick), .pick_idx(pick_idx), .any(pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ARB_IDLE;
      grant  <= '0;
      busy   <= 1'b0;
      last_q <= PTR_W'(N - 1);
    end else begin
      case (st_q)
        ARB_IDLE: begin
          if (pick_any) begin
            grant  <= pick;
            busy   <= 1'b1;
            last_q <= pick_idx;
            st_q   <= ((pick & req_ovf) != '0) ? ARB_OVF : ARB_HELD;
          end
        end
        default: begin
          if (release_w) begin
            grant <= '0;
            busy  <= 1'b0;
            st_q  <= ARB_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/seqph_commit_arb_chk.sv
module seqph_commit_arb_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] grant,
  input logic         busy,
  input logic [N-1:0] done,
  input logic [N-1:0] rpt_valid,
  input logic [N-1:0] elig,
  input logic         ovf_held
);
  // R2: never two holders
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R2: busy tracks an outstanding grant
  a_r2_busy: assert property (@(posedge clk) disable iff (rst)
    busy == (grant != '0));

  // R3: a new grant only goes to a request that was eligible
  a_r3_elig: assert property (@(posedge clk) disable iff (rst)
    ($past(grant) == '0 && grant != '0) |-> ((grant & ~$past(elig)) == '0));

  // R6: without done or end report, the grant does not move
  a_r6_keep: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && (grant & (done | rpt_valid)) == '0) |=> $stable(grant));

  // R9: an overflow holder ignores done
  a_r9_ovf_keep: assert property (@(posedge clk) disable iff (rst)
    (ovf_held && (grant & rpt_valid) == '0) |=> $stable(grant));
endmodule

bind seqph_commit_arb seqph_commit_arb_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .grant(grant), .busy(busy), .done(done),
  .rpt_valid(rpt_valid), .elig(elig_w), .ovf_held(ovf_held_w)
);

// File: tb/sim_seqph_commit_arb.sv
`timescale 1ns/100ps
module sim_seqph_commit_arb;
  localparam int N = 4, SW = 2, PW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] req = '0, req_ovf = '0, done = '0, rpt_valid = '0;
  logic [N*SW-1:0] req_seq = '0, rpt_seq = '0;
  logic [N*PW-1:0] req_phase = '0, rpt_phase = '0;
  logic [PW-1:0] done_inc = '0;
  logic done_wait = 1'b0, rpt_active = 1'b0;
  logic [SW-1:0] done_wseq = '0;
  logic [N-1:0] grant, hold;
  logic busy;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  seqph_commit_arb #(.N(N), .SEQ_W(SW), .PH_W(PW)) u0 (
    .clk(clk), .rst(rst), .req(req), .req_ovf(req_ovf), .req_seq(req_seq),
    .req_phase(req_phase), .done(done), .done_inc(done_inc),
    .done_wait(done_wait), .done_wseq(done_wseq), .rpt_valid(rpt_valid),
    .rpt_active(rpt_active), .rpt_seq(rpt_seq), .rpt_phase(rpt_phase),
    .grant(grant), .busy(busy), .hold(hold)
  );

  // Vector: {exp, act3, seq3, ph3, act2, seq2, ph2, seq0, ph0}
  localparam logic [20:0] VEC [8] = '{
    {1'b1, 1'b1, 2'd1, 4'd5,  1'b1, 2'd1, 4'd3, 2'd1, 4'd3},
    {1'b0, 1'b0, 2'd0, 4'd0,  1'b1, 2'd1, 4'd2, 2'd1, 4'd3},
    {1'b1, 1'b1, 2'd0, 4'd1,  1'b1, 2'd2, 4'd0, 2'd1, 4'd3},
    {1'b1, 1'b0, 2'd1, 4'd0,  1'b0, 2'd1, 4'd2, 2'd1, 4'd3},
    {1'b1, 1'b1, 2'd0, 4'd15, 1'b1, 2'd0, 4'd0, 2'd0, 4'd0},
    {1'b0, 1'b1, 2'd2, 4'd1,  1'b1, 2'd3, 4'd8, 2'd3, 4'd9},
    {1'b1, 1'b1, 2'd3, 4'd10, 1'b1, 2'd3, 4'd9, 2'd3, 4'd9},
    {1'b1, 1'b1, 2'd1, 4'd0,  1'b1, 2'd2, 4'd5, 2'd2, 4'd4}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_rpt(input int i, input logic [SW-1:0] s, input logic [PW-1:0] p);
    rpt_valid[i] = 1'b1;
    rpt_seq[i*SW +: SW] = s;
    rpt_phase[i*PW +: PW] = p;
  endtask

  task automatic set_req(input int i, input logic [SW-1:0] s, input logic [PW-1:0] p);
    req[i] = 1'b1;
    req_seq[i*SW +: SW] = s;
    req_phase[i*PW +: PW] = p;
  endtask

  task automatic clear_table();
    rpt_valid = '1; rpt_active = 1'b0; step();
    rpt_valid = '0; rpt_active = 1'b1;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1 reset state
    check("R1 grant", grant, 0);
    check("R1 busy", busy, 0);
    check("R1 hold", hold, 0);
    rpt_active = 1'b1;

    // R5 round robin among equal phases of one sequence
    set_rpt(0, 1, 0); set_rpt(1, 1, 0); set_rpt(2, 1, 0); step();
    rpt_valid = '0;
    set_req(0, 1, 0); set_req(1, 1, 0); set_req(2, 1, 0); step();
    check("R5 first from 0", grant, 4'b0001);
    check("R2 busy with grant", busy, 1);
    for (int k = 0; k < 3; k++) begin
      done = grant; done_inc = 0; step();
      done = '0;
      check("R11 idle after release", grant, 0);
      check("R2 busy idle", busy, 0);
      step();
      check("R5 rotation", grant, (k == 2) ? 4'b0001 : (4'b0010 << k));
    end
    done = grant; step(); done = '0; req = '0; step();

    // R3 R4 R10 table of eligibility vectors
    for (int v = 0; v < 8; v++) begin
      logic [20:0] e;
      e = VEC[v];
      clear_table();
      set_rpt(0, e[5:4], e[3:0]);
      if (e[12]) set_rpt(2, e[11:10], e[9:6]);
      if (e[19]) set_rpt(3, e[18:17], e[16:13]);
      step();
      rpt_valid = '0;
      if (!e[12]) begin rpt_active = 1'b0; set_rpt(2, e[11:10], e[9:6]); step(); rpt_valid = '0; rpt_active = 1'b1; end
      set_req(0, e[5:4], e[3:0]); step();
      check("R3 R4 R10 vector grant", grant, {3'b000, e[20]});
      req = '0;
      if (e[20]) begin done[0] = 1'b1; step(); done = '0; end
      step();
    end

    // R7 barrier and split, R6 phase latched on done
    clear_table();
    set_rpt(0, 0, 0); set_rpt(1, 0, 0); step(); rpt_valid = '0;
    set_req(0, 0, 0); step();
    check("R7 first grant", grant, 4'b0001);
    done[0] = 1'b1; done_inc = 1; req_phase[3:0] = 4'd1; step();
    done = '0; done_inc = 0;
    check("R6 release on done", grant, 0);
    step(); step();
    check("R7 barrier blocks", grant, 0);
    set_req(1, 0, 0); step();
    check("R7 peer at old phase", grant, 4'b0010);
    done[1] = 1'b1; done_inc = 1; req[1] = 1'b0; step();
    done = '0; done_inc = 0; step();
    check("R7 barrier passed", grant, 4'b0001);
    done[0] = 1'b1; done_inc = 0; step(); done = '0; step();
    check("R7 split keeps order", grant, 4'b0001);
    done[0] = 1'b1; req = '0; step(); done = '0; step();

    // R9 overflow holder ignores done and blocks others
    clear_table();
    set_rpt(3, 2, 0); set_rpt(0, 3, 0); step(); rpt_valid = '0;
    set_req(3, 2, 0); req_ovf[3] = 1'b1; step();
    check("R9 ovf grant", grant, 4'b1000);
    set_req(0, 3, 0); done[3] = 1'b1; step(); done = '0;
    check("R9 done ignored", grant, 4'b1000);
    step();
    check("R9 others blocked", grant, 4'b1000);
    rpt_active = 1'b0; set_rpt(3, 2, 0); req[3] = 1'b0; req_ovf = '0; step();
    rpt_valid = '0; rpt_active = 1'b1;
    check("R9 released by report", grant, 0);
    step();
    check("R9 next holder", grant, 4'b0001);
    done[0] = 1'b1; req = '0; step(); done = '0; step();

    // R8 wait for another sequence
    clear_table();
    set_rpt(1, 0, 0); set_rpt(2, 1, 0); step(); rpt_valid = '0;
    set_req(1, 0, 0); step();
    check("R8 grant", grant, 4'b0010);
    done[1] = 1'b1; done_wait = 1'b1; done_wseq = 1; req = '0; step();
    done = '0; done_wait = 1'b0;
    check("R8 hold set", hold, 4'b0010);
    step();
    check("R8 hold while live", hold, 4'b0010);
    rpt_active = 1'b0; set_rpt(2, 1, 0); step();
    rpt_valid = '0; rpt_active = 1'b1;
    check("R8 hold one edge after report", hold, 4'b0010);
    step();
    check("R8 hold cleared", hold, 0);

    finish_run();
  end
endmodule